// File: doc/BRIEF.md
# Virtual-Channel Ethernet Frame Packetizer

This block sits between a user stream and an Ethernet MAC, both 512 bits (64 bytes) wide. It wraps each user frame into one or more link frames. Each link frame is one header word, a run of payload words copied unchanged from the input, and one footer word. A user frame longer than `MAX_SIZE` bytes is cut into chunks. Every chunk after the first gets its own header and footer and keeps the same channel index. Because header, payload and footer all fill whole 64-byte words, no byte realignment is needed.

The header carries the addressing, a per-frame sequence number, the channel index, the local per-channel pause mask, a checksum, and two 128-bit side fields. The footer tells the far side:
- how full the last payload word was,
- how many payload bytes the chunk held,
- whether the chunk ends the user frame, and whether that frame ended in error,
- the pause mask latched while the payload was moving.

The input channel index is a sideband value that stays constant for the whole user frame.

Top module: `vcf_packetizer`

## Requirements
- R1: The header word places bytes as follows, with multi-byte fields least-significant byte first (byte k is data bits [8k+7:8k]):
  - bytes 0-5: destination MAC
  - bytes 6-11: source MAC
  - bytes 12-13: EtherType
  - byte 14: 0x01
  - byte 19: `s_tuser[7:0]` of the first payload beat of that chunk
  - byte 20: opcode enable
  - bytes 21-29: zero
  - bytes 32-47: opcode data
  - bytes 48-63: user data, sampled at the header transfer
  - byte 18: channel index in bits [3:0], zero in bits [7:4]
- R2: Header bytes 30-31 hold the bitwise inverse of the 16-bit ones'-complement sum of the other 31 little-endian 16-bit header words. The ones'-complement sum of all 32 words is therefore 0xFFFF.
- R3: Header byte 15 is a sequence number. It is 0 for the first frame after reset, goes up by one with each footer sent, and wraps from 255 to 0.
- R4: A chunk carries at most `MAX_SIZE/64` payload words (16 by default). When the input frame is longer, the footer follows that many words and a new header continues the frame with the same channel index. A frame of exactly 16 words produces one chunk.
- R5: Footer byte 0 holds the number of valid bytes (1-64) in the chunk's last payload word. Footer bytes 4-5 hold the chunk's total payload byte count. All footer bytes from 6 up are zero.
- R6: Footer byte 1 bit 0 (end of frame) is 1 only for the chunk that carries the input beat with `s_tlast`. Footer byte 1 bit 1 (frame error) is 1 only when that beat also has `s_tuser[0]` set.
- R7: Header bytes 16-17 show `pause_in` at the header transfer. Footer bytes 2-3 show `pause_in` as it was at the chunk's last accepted payload beat, whatever it does afterwards.
- R8: Payload words appear on the output with the input data and tkeep unchanged. `m_tlast` is set only on footer words. Header and footer words carry a full tkeep. `s_tready` is low while a header or footer is presented.
- R9: After reset, `m_tvalid` and `s_tready` are low until input data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | 512 | Input payload word |
| s_tkeep | input | 64 | Input byte enables |
| s_tlast | input | 1 | Last beat of user frame |
| s_tuser | input | TUSER_W | Input sideband; bit 0 flags an errored frame on its last beat |
| s_tvc | input | 4 | Channel index, held for the whole frame |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | MAC accepts output word |
| m_tdata | output | 512 | Output header, payload or footer word |
| m_tkeep | output | 64 | Output byte enables |
| m_tlast | output | 1 | Marks the footer word |
| cfg_dst_mac | input | 48 | Destination MAC |
| cfg_src_mac | input | 48 | Source MAC |
| cfg_ether_type | input | 16 | EtherType value |
| cfg_opcode_en | input | 8 | Opcode enable byte |
| cfg_opcode_data | input | 128 | Opcode data field |
| cfg_user_data | input | 128 | User data field |
| pause_in | input | 16 | Local per-channel pause mask |

## Verification
The bench drives the following frame shapes:

| Input pattern | What it separates |
|---|---|
| 3 words with a partly filled last word | Byte-count and valid-count encoding from a mistaken full-word count |
| 20 words ending in error | Split at the chunk limit; end and error markers on the last chunk only |
| Exactly 16 words | An off-by-one that would emit an empty extra chunk |
| Output back-pressure | Header and footer holding steady, no input taken during them |
| Run of 258 one-word frames | Sequence-number wrap |

In every frame the pause mask changes on each beat and again after the last beat. This shows whether the footer holds the latched value or the live one.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
   localparam int WORD_BYTES = 64;
   localparam int WORD_BITS  = WORD_BYTES * 8;

   typedef enum logic [1:0] {
      ST_HDR = 2'd0,
      ST_PAY = 2'd1,
      ST_FTR = 2'd2
   } vcf_state_e;

   function automatic logic [15:0] ocs_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction
endpackage

// File: rtl/vcf_hdr_build.sv
module vcf_hdr_build
   import vcf_pkg::*;
(
   input  logic [47:0]          dst_mac,
   input  logic [47:0]          src_mac,
   input  logic [15:0]          ether_type,
   input  logic [7:0]           seq,
   input  logic [15:0]          pause,
   input  logic [3:0]           vc,
   input  logic [7:0]           user_first,
   input  logic [7:0]           opcode_en,
   input  logic [127:0]         opcode_data,
   input  logic [127:0]         user_data,
   output logic [WORD_BITS-1:0] hdr
);
   localparam int N_HALF = WORD_BITS / 16;
   localparam int CS_IDX = 15;

   logic [WORD_BITS-1:0] base;
   logic [15:0]          acc;

   always_comb begin
      base           = '0;
      base[47:0]     = dst_mac;
      base[95:48]    = src_mac;
      base[111:96]   = ether_type;
      base[119:112]  = 8'h01;
      base[127:120]  = seq;
      base[143:128]  = pause;
      base[151:144]  = {4'd0, vc};
      base[159:152]  = user_first;
      base[167:160]  = opcode_en;
      base[383:256]  = opcode_data;
      base[511:384]  = user_data;
   end

   always_comb begin
      acc = 16'd0;
      for (int k = 0; k < N_HALF; k++) begin
         if (k != CS_IDX) acc = ocs_add(acc, base[16*k +: 16]);
      end
   end

   always_comb begin
      hdr                    = base;
      hdr[16*CS_IDX +: 16]   = ~acc;
   end
endmodule

// File: rtl/vcf_ftr_build.sv
module vcf_ftr_build
   import vcf_pkg::*;
#(
   parameter int BYTE_W = 11
) (
   input  logic [7:0]           last_valid,
   input  logic                 eof,
   input  logic                 eofe,
   input  logic [15:0]          pause,
   input  logic [BYTE_W-1:0]    nbytes,
   output logic [WORD_BITS-1:0] ftr
);
   always_comb begin
      ftr        = '0;
      ftr[7:0]   = last_valid;
      ftr[8]     = eof;
      ftr[9]     = eofe;
      ftr[31:16] = pause;
      ftr[47:32] = 16'(nbytes);
   end
endmodule

// File: rtl/vcf_chunk_ctrl.sv
module vcf_chunk_ctrl
   import vcf_pkg::*;
#(
   parameter int MAX_WORDS = 16,
   parameter int BYTE_W    = 11,
   localparam int BEAT_W   = $clog2(MAX_WORDS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s_tvalid,
   input  logic                s_tlast,
   input  logic [WORD_BYTES-1:0] s_tkeep,
   input  logic                s_err,
   input  logic [3:0]          s_tvc,
   input  logic [15:0]         pause_m,
   input  logic                m_tready,
   output vcf_state_e          state,
   output logic                m_tvalid,
   output logic                s_tready,
   output logic [7:0]          seq_q,
   output logic [3:0]          hdr_vc,
   output logic [7:0]          last_valid_q,
   output logic [BYTE_W-1:0]   bytes_q,
   output logic                eof_q,
   output logic                eofe_q,
   output logic [15:0]         pause_lat_q
);
   logic [BEAT_W-1:0] beat_q;
   logic              cont_q;
   logic [3:0]        vc_q;
   logic [6:0]        pop;

   always_comb begin
      pop = 7'd0;
      for (int i = 0; i < WORD_BYTES; i++) pop = pop + 7'(s_tkeep[i]);
   end

   assign m_tvalid = (state == ST_FTR) ? 1'b1 : s_tvalid;
   assign s_tready = (state == ST_PAY) && m_tready;
   assign hdr_vc   = cont_q ? vc_q : s_tvc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_HDR;
         seq_q        <= 8'd0;
         beat_q       <= '0;
         bytes_q      <= '0;
         last_valid_q <= 8'd0;
         eof_q        <= 1'b0;
         eofe_q       <= 1'b0;
         pause_lat_q  <= 16'd0;
         cont_q       <= 1'b0;
         vc_q         <= 4'd0;
      end else begin
         unique case (state)
            ST_HDR: if (s_tvalid && m_tready) begin
               state   <= ST_PAY;
               beat_q  <= '0;
               bytes_q <= '0;
               if (!cont_q) vc_q <= s_tvc;
            end
            ST_PAY: if (s_tvalid && m_tready) begin
               beat_q       <= beat_q + 1'b1;
               bytes_q      <= bytes_q + BYTE_W'(pop);
               last_valid_q <= 8'(pop);
               pause_lat_q  <= pause_m;
               if (s_tlast) begin
                  state  <= ST_FTR;
                  eof_q  <= 1'b1;
                  eofe_q <= s_err;
                  cont_q <= 1'b0;
               end else if (beat_q == BEAT_W'(MAX_WORDS - 1)) begin
                  state  <= ST_FTR;
                  eof_q  <= 1'b0;
                  eofe_q <= 1'b0;
                  cont_q <= 1'b1;
               end
            end
            ST_FTR: if (m_tready) begin
               state <= ST_HDR;
               seq_q <= seq_q + 8'd1;
            end
            default: state <= ST_HDR;
         endcase
      end
   end

   AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      beat_q <= BEAT_W'(MAX_WORDS)); // R4
   AST_SPLIT_TO_FTR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PAY && s_tvalid && m_tready && !s_tlast && beat_q == BEAT_W'(MAX_WORDS - 1))
      |=> (state == ST_FTR && !eof_q)); // R4
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FTR && m_tready) |=> (seq_q == $past(seq_q) + 8'd1)); // R3
   AST_FTR_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FTR && !m_tready) |=> $stable(pause_lat_q)); // R7
   AST_ERR_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      eofe_q |-> eof_q); // R6
endmodule

// File: rtl/vcf_packetizer.sv
module vcf_packetizer
   import vcf_pkg::*;
#(
   parameter int MAX_SIZE = 1024,
   parameter int NUM_VC   = 16,
   parameter int TUSER_W  = 8,
   parameter int ERR_BIT  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 s_tvalid,
   output logic                 s_tready,
   input  logic [511:0]         s_tdata,
   input  logic [63:0]          s_tkeep,
   input  logic                 s_tlast,
   input  logic [TUSER_W-1:0]   s_tuser,
   input  logic [3:0]           s_tvc,
   output logic                 m_tvalid,
   input  logic                 m_tready,
   output logic [511:0]         m_tdata,
   output logic [63:0]          m_tkeep,
   output logic                 m_tlast,
   input  logic [47:0]          cfg_dst_mac,
   input  logic [47:0]          cfg_src_mac,
   input  logic [15:0]          cfg_ether_type,
   input  logic [7:0]           cfg_opcode_en,
   input  logic [127:0]         cfg_opcode_data,
   input  logic [127:0]         cfg_user_data,
   input  logic [15:0]          pause_in
);
   localparam int MAX_WORDS = MAX_SIZE / WORD_BYTES;
   localparam int BYTE_W    = $clog2(MAX_SIZE + 1);

   if (MAX_SIZE % WORD_BYTES != 0 || MAX_SIZE < WORD_BYTES || MAX_SIZE > 65535) begin : g_bad_size
      $error("MAX_SIZE must be a multiple of 64 between 64 and 65535");
   end
   if (NUM_VC < 1 || NUM_VC > 16) begin : g_bad_vc
      $error("NUM_VC must be 1 to 16");
   end
   if (TUSER_W < 8 || ERR_BIT >= TUSER_W) begin : g_bad_user
      $error("TUSER_W must be at least 8 and hold ERR_BIT");
   end

   logic [15:0] pause_m;
   for (genvar g = 0; g < 16; g++) begin : g_pause
      if (g < NUM_VC) begin : g_on
         assign pause_m[g] = pause_in[g];
      end else begin : g_off
         assign pause_m[g] = 1'b0;
      end
   end

   vcf_state_e        state;
   logic [7:0]        seq_q;
   logic [3:0]        hdr_vc;
   logic [7:0]        last_valid_q;
   logic [BYTE_W-1:0] bytes_q;
   logic              eof_q, eofe_q;
   logic [15:0]       pause_lat_q;
   logic [511:0]      hdr_word, ftr_word;

   vcf_chunk_ctrl #(.MAX_WORDS(MAX_WORDS), .BYTE_W(BYTE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tkeep(s_tkeep),
      .s_err(s_tuser[ERR_BIT]), .s_tvc(s_tvc), .pause_m(pause_m),
      .m_tready(m_tready), .state(state), .m_tvalid(m_tvalid),
      .s_tready(s_tready), .seq_q(seq_q), .hdr_vc(hdr_vc),
      .last_valid_q(last_valid_q), .bytes_q(bytes_q),
      .eof_q(eof_q), .eofe_q(eofe_q), .pause_lat_q(pause_lat_q)
   );

   vcf_hdr_build u_hdr (
      .dst_mac(cfg_dst_mac), .src_mac(cfg_src_mac), .ether_type(cfg_ether_type),
      .seq(seq_q), .pause(pause_m), .vc(hdr_vc), .user_first(s_tuser[7:0]),
      .opcode_en(cfg_opcode_en), .opcode_data(cfg_opcode_data),
      .user_data(cfg_user_data), .hdr(hdr_word)
   );

   vcf_ftr_build #(.BYTE_W(BYTE_W)) u_ftr (
      .last_valid(last_valid_q), .eof(eof_q), .eofe(eofe_q),
      .pause(pause_lat_q), .nbytes(bytes_q), .ftr(ftr_word)
   );

   always_comb begin
      unique case (state)
         ST_PAY: begin
            m_tdata = s_tdata;
            m_tkeep = s_tkeep;
            m_tlast = 1'b0;
         end
         ST_FTR: begin
            m_tdata = ftr_word;
            m_tkeep = '1;
            m_tlast = 1'b1;
         end
         default: begin
            m_tdata = hdr_word;
            m_tkeep = '1;
            m_tlast = 1'b0;
         end
      endcase
   end

   AST_NO_INPUT_AT_FTR: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tlast) |-> !s_tready); // R8
   AST_FTR_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tlast && !m_tready) |=> (m_tvalid && m_tlast && $stable(m_tdata))); // R5
endmodule

// File: tb/tb_vcf_packetizer.sv
module tb_vcf_packetizer;
   logic clk = 1'b0, rst_n = 1'b0;
   logic s_tvalid = 0, s_tlast = 0, m_tready = 1;
   logic [511:0] s_tdata = '0;
   logic [63:0]  s_tkeep = '0;
   logic [7:0]   s_tuser = '0;
   logic [3:0]   s_tvc = '0;
   logic [15:0]  pause_in = '0;
   logic [127:0] user_data = '0;
   logic         s_tready, m_tvalid, m_tlast;
   logic [511:0] m_tdata;
   logic [63:0]  m_tkeep;

   localparam logic [47:0]  DST = 48'h0A0B0C0D0E0F;
   localparam logic [47:0]  SRC = 48'h112233445566;
   localparam logic [15:0]  ETY = 16'h88B5;
   localparam logic [7:0]   OPE = 8'h5A;
   localparam logic [127:0] OPD = 128'hCAFE_0001_0002_0003_0004_0005_0006_0007;

   vcf_packetizer dut (
      .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tuser(s_tuser),
      .s_tvc(s_tvc), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
      .m_tkeep(m_tkeep), .m_tlast(m_tlast), .cfg_dst_mac(DST), .cfg_src_mac(SRC),
      .cfg_ether_type(ETY), .cfg_opcode_en(OPE), .cfg_opcode_data(OPD),
      .cfg_user_data(user_data), .pause_in(pause_in)
   );

   always #10 clk = ~clk;

   int checks = 0, fails = 0, gap_err = 0, rec_n = 0;
   logic [511:0] rd [64];
   logic [63:0]  rk [64];
   logic         rl [64];
   bit           bp_en = 0;
   logic [2:0]   bp_cnt = 0;
   logic [7:0]   exp_seq = 0;

   always @(posedge clk) begin
      bp_cnt   <= bp_cnt + 1;
      m_tready <= bp_en ? (bp_cnt[0] | bp_cnt[2]) : 1'b1;
   end

   always @(negedge clk) begin
      if (m_tvalid && m_tready && rec_n < 64) begin
         rd[rec_n] = m_tdata; rk[rec_n] = m_tkeep; rl[rec_n] = m_tlast;
         rec_n++;
      end
      if (m_tvalid && m_tlast && s_tready) gap_err++;
   end

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [511:0] pat(input logic [15:0] seed, input int i);
      return {16{seed, 16'(i)}};
   endfunction

   function automatic logic [63:0] keep_of(input int n);
      return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
   endfunction

   task automatic push(input logic [15:0] seed, input int i, input bit last,
                       input int lastkeep, input bit err, input logic [3:0] vc, input logic [15:0] pbase);
      s_tvalid = 1; s_tdata = pat(seed, i); s_tlast = last;
      s_tkeep  = last ? keep_of(lastkeep) : '1;
      s_tuser  = 8'(i * 2) | {7'd0, last & err};
      s_tvc    = vc; pause_in = pbase + 16'(i);
      do @(negedge clk); while (!s_tready);
      @(posedge clk); #1;
   endtask

   task automatic send_frame(input logic [15:0] seed, input int n, input int lastkeep,
                             input bit err, input logic [3:0] vc, input logic [15:0] pbase);
      for (int i = 0; i < n; i++) push(seed, i, i == n-1, lastkeep, err, vc, pbase);
      s_tvalid = 0; s_tlast = 0;
      pause_in = 16'hFFFF;
      repeat (14) @(negedge clk);
   endtask

   task automatic check_chunk(input int at, input int nw, input int first_i, input logic [3:0] vc,
                              input int lastkeep, input int nbytes, input bit eof, input bit eofe,
                              input logic [15:0] seed, input logic [15:0] pbase, input logic [127:0] ud);
      logic [511:0] h, f;
      logic [15:0]  acc;
      logic [16:0]  s;
      h = rd[at]; f = rd[at+nw+1];
      check(h[111:0] == {ETY, SRC, DST} && h[119:112] == 8'h01, "R1 addr/type/version",
            128'(h[119:0]), {8'h01, ETY, SRC, DST});
      check(h[151:144] == {4'd0, vc} && h[159:152] == 8'(first_i*2), "R1 vc/tuser byte",
            128'(h[159:144]), 128'({8'(first_i*2), 4'd0, vc}));
      check(h[167:160] == OPE && h[239:168] == '0 && h[383:256] == OPD && h[511:384] == ud,
            "R1 opcode/reserved/user", h[511:384], ud);
      check(!rl[at] && rk[at] == '1, "R8 header tkeep/tlast", 128'(rk[at]), 128'(64'hFFFFFFFFFFFFFFFF));
      acc = 0;
      for (int k = 0; k < 32; k++) begin
         s = {1'b0, acc} + {1'b0, h[16*k +: 16]};
         acc = s[15:0] + {15'd0, s[16]};
      end
      check(acc == 16'hFFFF, "R2 header checksum", 128'(acc), 128'(16'hFFFF));
      check(h[127:120] == exp_seq, "R3 sequence", 128'(h[127:120]), 128'(exp_seq));
      check(h[143:128] == pbase + 16'(first_i), "R7 header pause", 128'(h[143:128]), 128'(pbase + 16'(first_i)));
      for (int j = 0; j < nw; j++) begin
         logic [63:0] ek;
         ek = (first_i + j == first_i + nw - 1 && eof) ? keep_of(lastkeep) : '1;
         check(rd[at+1+j] == pat(seed, first_i+j) && rk[at+1+j] == ek && !rl[at+1+j],
               "R8 payload passthrough", rd[at+1+j][127:0], pat(seed, first_i+j)[127:0]);
      end
      check(rl[at+nw+1] && rk[at+nw+1] == '1, "R4 footer after chunk words", 128'(rl[at+nw+1]), 128'(1));
      check(f[7:0] == 8'(eof ? lastkeep : 64) && f[47:32] == 16'(nbytes) && f[511:48] == '0,
            "R5 footer counts", 128'(f[47:0]), 128'({16'(nbytes), 16'h0, 16'(eof ? lastkeep : 64)}));
      check(f[8] == eof && f[9] == eofe && f[15:10] == 0, "R6 end/error markers",
            128'(f[15:8]), 128'({eofe, eof}));
      check(f[31:16] == pbase + 16'(first_i + nw - 1), "R7 footer latched pause",
            128'(f[31:16]), 128'(pbase + 16'(first_i + nw - 1)));
      exp_seq++;
   endtask

   task automatic t_reset;
      check(!m_tvalid && !s_tready, "R9 reset idle", 128'({m_tvalid, s_tready}), 128'(0));
   endtask

   task automatic t_short;
      rec_n = 0; user_data = 128'h1111;
      send_frame(16'hA001, 3, 10, 0, 4'd5, 16'h0100);
      check(rec_n == 5, "R4 short frame beat total", 128'(rec_n), 128'(5));
      check_chunk(0, 3, 0, 4'd5, 10, 138, 1, 0, 16'hA001, 16'h0100, 128'h1111);
   endtask

   task automatic t_split_err;
      rec_n = 0; user_data = 128'h2222;
      send_frame(16'hB002, 20, 33, 1, 4'd12, 16'h0200);
      check(rec_n == 24, "R4 split frame beat total", 128'(rec_n), 128'(24));
      check_chunk(0, 16, 0, 4'd12, 64, 1024, 0, 0, 16'hB002, 16'h0200, 128'h2222);
      check_chunk(18, 4, 16, 4'd12, 33, 3*64+33, 1, 1, 16'hB002, 16'h0200, 128'h2222);
   endtask

   task automatic t_exact;
      rec_n = 0; user_data = 128'h3333;
      send_frame(16'hC003, 16, 64, 0, 4'd15, 16'h0300);
      check(rec_n == 18, "R4 exact-size single chunk", 128'(rec_n), 128'(18));
      check_chunk(0, 16, 0, 4'd15, 64, 1024, 1, 0, 16'hC003, 16'h0300, 128'h3333);
   endtask

   task automatic t_backpressure;
      rec_n = 0; user_data = 128'h4444; bp_en = 1;
      send_frame(16'hD004, 5, 1, 1, 4'd3, 16'h0400);
      repeat (10) @(negedge clk);
      bp_en = 0;
      repeat (4) @(negedge clk);
      check(rec_n == 7, "R8 back-pressure beat total", 128'(rec_n), 128'(7));
      check_chunk(0, 5, 0, 4'd3, 1, 4*64+1, 1, 1, 16'hD004, 16'h0400, 128'h4444);
      check(gap_err == 0, "R8 no input during footer", 128'(gap_err), 128'(0));
   endtask

   task automatic t_wrap;
      for (int k = 0; k < 258; k++) begin
         rec_n = 0;
         send_frame(16'hE000 + 16'(k), 1, 64, 0, 4'(k), 16'h0500);
         check(rec_n == 3 && rd[0][127:120] == exp_seq, "R3 sequence wrap",
               128'(rd[0][127:120]), 128'(exp_seq));
         exp_seq++;
      end
   endtask

   initial begin
      fork
         begin
            repeat (5) @(posedge clk);
            #1 rst_n = 1;
            @(negedge clk);
            t_reset();
            t_short();
            t_split_err();
            t_exact();
            t_backpressure();
            t_wrap();
            t_reset();
         end
         begin
            repeat (100000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule